// File: doc/BRIEF.md
# Fan PWM Spin-up Controller

This block manages the start of three PWM-driven fan channels. When a channel is told to start, it drives that channel's duty output to full scale for a programmed spin-up interval. It then hands the output back to the duty value requested by the rest of the fan loop. Each channel has a selection bit that allows the interval to finish early, as soon as that channel's tach reading rises above a programmed tach minimum. Whichever comes first, the tach crossing or the timer, ends the interval.

A small register file holds the configuration and is reached through a plain synchronous read/write bus. It contains a control register with a run bit and a lock bit, one spin-up time code per channel, one tach minimum per channel, and the spin-up selection register. Time codes map to a fixed set of millisecond values. These values are scaled by the `TICKS_PER_MS` parameter, so a short tick can be used in simulation. Duty requests, tach readings and duty outputs are level signals sampled every cycle, with no handshake. Bus reads have one cycle of latency.

Top module: `fan_spinup_ctrl`

## Requirements
- R1: After reset, register reads return 07h at 75h, 00h at 40h, 01h at 50h..52h and FFh at 58h..5Ah, and every spin_busy bit is 0.
- R2: The register at 75h holds one selection bit per channel in bits 2:0 (bit i for channel i). Bits 7:3 read as 0, and writes to them are dropped.
- R3: With a channel's effective selection bit at 0, spin_busy stays high for exactly max(T,1) cycles, where T = ms(code) * TICKS_PER_MS.
- R4: With the effective selection bit at 1, spin-up ends at the first clock edge after the trigger where tach > tach minimum, or when the R3 time elapses, whichever comes first.
- R5: A channel triggers when the run bit (40h bit 0) is set and either the run bit rose on the previous edge (all channels) or its duty request went from zero to nonzero. spin_busy rises on that edge. A trigger during spin-up restarts the timer. Duty changes while the run bit is clear trigger nothing.
- R6: pwm_duty of a channel is FFh while its spin_busy is high, and equals its duty request otherwise.
- R7: Once the lock bit (40h bit 1) is set, writes to 75h are ignored.
- R8: The lock bit is sticky: writing 0 to it has no effect, and only reset clears it.
- R9: While the run bit is clear, spin-up control uses 07h as the selection value. The register at 75h can still be written and read back.
- R10: Reads at any address not listed return 00h. Writes to such addresses change nothing.
- R11: bus_rdata updates on the edge that samples bus_rd, and holds its value otherwise.
- R12: Time codes 0..7 at 50h+i (bits 2:0) select 0, 100, 250, 400, 700, 1000, 2000 and 4000 ms.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after bus_rd |
| duty_req | input | 24 | Requested duty, 8 bits per channel, channel 0 in bits 7:0 |
| tach_val | input | 24 | Tach reading, 8 bits per channel |
| pwm_duty | output | 24 | Duty output, 8 bits per channel |
| spin_busy | output | 3 | Spin-up active, one bit per channel |

## Verification
The assertions assume that bus_rd and bus_wr are never asserted together. They also assume that every input changes away from the rising edge, so the value sampled by the block is the value the checker sees. The bench drives all inputs on the falling edge, issues single-cycle strobes one at a time, and holds tach and duty values stable between stimulus steps. Its reference model tracks every register, timer and edge detector behaviourally. The model is compared with spin_busy, pwm_duty and bus_rdata shortly after each rising edge.

// File: rtl/fsu_pkg.sv
package fsu_pkg;
  localparam int unsigned DW = 8;
  localparam logic [7:0] A_CTRL   = 8'h40;
  localparam logic [7:0] A_TIME   = 8'h50;
  localparam logic [7:0] A_TMIN   = 8'h58;
  localparam logic [7:0] A_SELECT = 8'h75;
  localparam logic [2:0] SEL_DEFAULT  = 3'b111;
  localparam logic [2:0] TIME_DEFAULT = 3'd1;

  function automatic int unsigned code_to_ms(input logic [2:0] code);
    case (code)
      3'd0: return 0;
      3'd1: return 100;
      3'd2: return 250;
      3'd3: return 400;
      3'd4: return 700;
      3'd5: return 1000;
      3'd6: return 2000;
      default: return 4000;
    endcase
  endfunction
endpackage

// File: rtl/fsu_regs.sv
module fsu_regs #(
  parameter int NCH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic             rd,
  input  logic [7:0]       addr,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata,
  output logic             run,
  output logic [NCH-1:0]   sel_eff,
  output logic [NCH*3-1:0] time_code,
  output logic [NCH*8-1:0] tach_min
);
  import fsu_pkg::*;

  logic           run_q, lock_q;
  logic [NCH-1:0] sel_q;
  logic [2:0]     time_q [NCH];
  logic [7:0]     tmin_q [NCH];
  logic [7:0]     rd_mux;
  logic           hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      lock_q <= 1'b0;
      sel_q  <= SEL_DEFAULT[NCH-1:0];
    end else if (wr) begin
      if (addr == A_CTRL) begin
        run_q  <= wdata[0];
        lock_q <= lock_q | wdata[1];
      end
      if (addr == A_SELECT && !lock_q) sel_q <= wdata[NCH-1:0];
    end
  end

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_ch
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          time_q[i] <= TIME_DEFAULT;
          tmin_q[i] <= 8'hFF;
        end else if (wr) begin
          if (addr == A_TIME + 8'(i)) time_q[i] <= wdata[2:0];
          if (addr == A_TMIN + 8'(i)) tmin_q[i] <= wdata;
        end
      end
      assign time_code[i*3 +: 3] = time_q[i];
      assign tach_min[i*8 +: 8]  = tmin_q[i];
    end
  endgenerate

  always_comb begin
    rd_mux = 8'h00;
    hit    = 1'b0;
    if (addr == A_CTRL) begin
      rd_mux = {6'b0, lock_q, run_q};
      hit    = 1'b1;
    end
    if (addr == A_SELECT) begin
      rd_mux[NCH-1:0] = sel_q;
      hit             = 1'b1;
    end
    for (int i = 0; i < NCH; i++) begin
      if (addr == A_TIME + 8'(i)) begin
        rd_mux = {5'b0, time_q[i]};
        hit    = 1'b1;
      end
      if (addr == A_TMIN + 8'(i)) begin
        rd_mux = tmin_q[i];
        hit    = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= 8'h00;
    else if (rd) rdata <= rd_mux;
  end

  assign run     = run_q;
  assign sel_eff = run_q ? sel_q : SEL_DEFAULT[NCH-1:0];

  p_lock_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);
  p_select_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && wr && addr == A_SELECT) |=> $stable(sel_q));
  p_undef_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !hit) |=> rdata == 8'h00);
  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(rdata));
endmodule

// File: rtl/fsu_channel.sv
module fsu_channel #(
  parameter int TICKS_PER_MS = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       run_rise,
  input  logic       early_en,
  input  logic [2:0] time_code,
  input  logic [7:0] tach_min,
  input  logic [7:0] tach,
  input  logic [7:0] duty_req,
  output logic       busy,
  output logic [7:0] pwm
);
  localparam int MAX_TICKS = 4000 * TICKS_PER_MS;
  localparam int CNT_W     = $clog2(MAX_TICKS + 1);

  logic [CNT_W-1:0] cnt_q, load;
  logic [7:0]       duty_prev_q;
  logic             trig, early_hit, busy_q;

  assign load      = CNT_W'(fsu_pkg::code_to_ms(time_code) * TICKS_PER_MS);
  assign trig      = run && (run_rise || (duty_req != 8'h00 && duty_prev_q == 8'h00));
  assign early_hit = early_en && (tach > tach_min);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q      <= 1'b0;
      cnt_q       <= '0;
      duty_prev_q <= 8'h00;
    end else begin
      duty_prev_q <= duty_req;
      if (trig) begin
        busy_q <= 1'b1;
        cnt_q  <= load;
      end else if (busy_q) begin
        if (early_hit || cnt_q <= CNT_W'(1)) busy_q <= 1'b0;
        else                                 cnt_q  <= cnt_q - 1'b1;
      end
    end
  end

  assign busy = busy_q;
  assign pwm  = busy_q ? 8'hFF : duty_req;

  p_start_needs_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(run));
  p_early_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && early_hit && !trig) |=> !busy_q);
  p_timer_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !early_hit && cnt_q > CNT_W'(1)) |=> busy_q);
endmodule

// File: rtl/fan_spinup_ctrl.sv
module fan_spinup_ctrl #(
  parameter int TICKS_PER_MS = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [7:0]  bus_addr,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  input  logic [23:0] duty_req,
  input  logic [23:0] tach_val,
  output logic [23:0] pwm_duty,
  output logic [2:0]  spin_busy
);
  localparam int NCH = 3;

  logic           run, run_d_q;
  logic [NCH-1:0] sel_eff;
  logic [NCH*3-1:0] time_code;
  logic [NCH*8-1:0] tach_min;

  fsu_regs #(.NCH(NCH)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .rd(bus_rd), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(bus_rdata), .run(run), .sel_eff(sel_eff),
    .time_code(time_code), .tach_min(tach_min)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_d_q <= 1'b0;
    else        run_d_q <= run;
  end

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_fan
      fsu_channel #(.TICKS_PER_MS(TICKS_PER_MS)) u_ch (
        .clk(clk), .rst_n(rst_n), .run(run), .run_rise(run && !run_d_q),
        .early_en(sel_eff[i]), .time_code(time_code[i*3 +: 3]),
        .tach_min(tach_min[i*8 +: 8]), .tach(tach_val[i*8 +: 8]),
        .duty_req(duty_req[i*8 +: 8]), .busy(spin_busy[i]),
        .pwm(pwm_duty[i*8 +: 8])
      );
    end
  endgenerate

  p_full_duty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    spin_busy[0] |-> pwm_duty[7:0] == 8'hFF);
endmodule

// File: tb/fan_spinup_ctrl_tb.sv
module fan_spinup_ctrl_tb;
  localparam int TPM = 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = 8'h00, bus_wdata = 8'h00;
  logic [7:0]  bus_rdata;
  logic [7:0]  duty [3] = '{8'h00, 8'h00, 8'h00};
  logic [7:0]  tach [3] = '{8'h00, 8'h00, 8'h00};
  logic [23:0] pwm_duty;
  logic [2:0]  spin_busy;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  fan_spinup_ctrl #(.TICKS_PER_MS(TPM)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .duty_req({duty[2], duty[1], duty[0]}), .tach_val({tach[2], tach[1], tach[0]}),
    .pwm_duty(pwm_duty), .spin_busy(spin_busy)
  );

  function automatic int ms_of(input int code);
    int t [8] = '{0, 100, 250, 400, 700, 1000, 2000, 4000};
    return t[code & 7];
  endfunction

  // behavioural reference
  int m_run, m_run_d, m_lock, m_sel, m_rdata;
  int m_time [3], m_tmin [3], m_busy [3], m_left [3], m_prev [3];

  function automatic int m_read(input int a);
    if (a == 'h40) return m_lock * 2 + m_run;
    if (a == 'h75) return m_sel;
    if (a >= 'h50 && a <= 'h52) return m_time[a - 'h50];
    if (a >= 'h58 && a <= 'h5A) return m_tmin[a - 'h58];
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 0; m_run_d = 0; m_lock = 0; m_sel = 7; m_rdata = 0;
      for (int i = 0; i < 3; i++) begin
        m_time[i] = 1; m_tmin[i] = 255; m_busy[i] = 0; m_left[i] = 0; m_prev[i] = 0;
      end
    end else begin
      int eff;
      eff = m_run ? m_sel : 7;
      for (int i = 0; i < 3; i++) begin
        bit trig, early;
        trig  = m_run && ((m_run_d == 0) || (duty[i] != 0 && m_prev[i] == 0));
        early = ((eff >> i) & 1) && (int'(tach[i]) > m_tmin[i]);
        if (trig) begin
          m_busy[i] = 1; m_left[i] = ms_of(m_time[i]) * TPM;
        end else if (m_busy[i]) begin
          if (early || m_left[i] <= 1) m_busy[i] = 0;
          else m_left[i]--;
        end
        m_prev[i] = duty[i];
      end
      m_run_d = m_run;
      if (bus_rd) m_rdata = m_read(bus_addr);
      if (bus_wr) begin
        if (bus_addr == 8'h40) begin
          m_run = bus_wdata[0];
          if (bus_wdata[1]) m_lock = 1;
        end
        if (bus_addr == 8'h75 && !m_lock) m_sel = bus_wdata & 7;
        if (bus_addr >= 8'h50 && bus_addr <= 8'h52) m_time[bus_addr - 8'h50] = bus_wdata & 7;
        if (bus_addr >= 8'h58 && bus_addr <= 8'h5A) m_tmin[bus_addr - 8'h58] = bus_wdata;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare on every clock, away from the edge
  always @(posedge clk) begin
    #3;
    if (rst_n && !done) begin
      for (int i = 0; i < 3; i++) begin
        int ep;
        check(spin_busy[i] == m_busy[i][0], "R3/R4/R5 spin_busy", spin_busy[i], m_busy[i]);
        ep = m_busy[i] ? 255 : int'(duty[i]);
        check(int'(pwm_duty[i*8 +: 8]) == ep, "R6 pwm_duty", pwm_duty[i*8 +: 8], ep);
      end
      check(int'(bus_rdata) == m_rdata, "R11 bus_rdata", bus_rdata, m_rdata);
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input int exp, input string tag);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0;
    check(int'(bus_rdata) == exp, tag, bus_rdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check(spin_busy == 3'b000, "R1 busy after reset", spin_busy, 0);
    rd(8'h75, 8'h07, "R1 select default");
    rd(8'h40, 8'h00, "R1 control default");
    rd(8'h50, 8'h01, "R1 time default");
    rd(8'h5A, 8'hFF, "R1 tach min default");
    rd(8'h10, 8'h00, "R10 undefined read");
    wr(8'h10, 8'hAA);
    rd(8'h10, 8'h00, "R10 undefined write ignored");
    rd(8'h51, 8'h01, "R10 defined regs untouched");
    wr(8'h50, 8'h01); wr(8'h51, 8'h02); wr(8'h52, 8'h00);
    rd(8'h51, 8'h02, "R12 time code readback");
    wr(8'h75, 8'h00);
    rd(8'h75, 8'h00, "R9 select writable while stopped");
    wr(8'h75, 8'hF8);
    rd(8'h75, 8'h00, "R2 reserved bits read zero");
    duty[0] = 8'h40; idle(5);
    check(spin_busy == 3'b000, "R5 no trigger while stopped", spin_busy, 0);
    wr(8'h40, 8'h01);                  // run rises: all channels, R5 R12
    idle(300);
    wr(8'h58, 8'h80); tach[0] = 8'h90; // select 0: full time, R3
    duty[0] = 8'h00; idle(1); duty[0] = 8'h40; idle(120);
    wr(8'h75, 8'h01);                  // select 1: early end, R4
    duty[0] = 8'h00; idle(1); duty[0] = 8'h40; idle(10);
    tach[0] = 8'h10;                   // timer running, tach crosses later
    duty[0] = 8'h00; idle(1); duty[0] = 8'h40; idle(30);
    tach[0] = 8'h90; idle(10);
    duty[1] = 8'h20; idle(40);         // retrigger mid spin-up, R5
    duty[1] = 8'h00; idle(1); duty[1] = 8'h30; idle(300);
    wr(8'h75, 8'h00); tach[0] = 8'h90; // stop during spin-up uses default, R9
    duty[0] = 8'h00; idle(1); duty[0] = 8'h40; idle(20);
    wr(8'h40, 8'h00); idle(5);
    check(spin_busy[0] == 1'b0, "R9 default select ends spin-up", spin_busy[0], 0);
    wr(8'h40, 8'h03);
    rd(8'h40, 8'h03, "R7 lock set");
    wr(8'h75, 8'h05);
    rd(8'h75, 8'h00, "R7 locked select write ignored");
    wr(8'h40, 8'h01);
    rd(8'h40, 8'h03, "R8 lock sticky");
    wr(8'h40, 8'h00);
    rd(8'h40, 8'h02, "R8 lock stays with run clear");
    wr(8'h51, 8'h07); tach[0] = 8'h00;
    wr(8'h40, 8'h01); idle(4100);       // longest code, R12
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule